// File: doc/BRIEF.md
# CCD Clock Pattern Sequencer

The block drives sixteen CCD clock and control lines from a two-level microprogram. A pattern memory holds 16-bit words. Bit i of a word sets line i high or low. A program memory holds entries. Each entry names a block of pattern words by its base address and length, states how many times to play that block, and may mark itself as the final entry. While running, the block emits exactly one pattern word per clock cycle. It steps through the words of a block in order, repeats the block as the entry asks, and then moves on to the next program entry.

Both memories are loaded through plain write ports while the sequencer is idle. A start pulse launches the program from entry 0. A stop pulse halts it at once. The busy output shows whether the program is running. The lines are registered, and they keep the last word that was played whenever the sequencer is idle.

Top module: `ccd_seq_top`

## Requirements
- R1: After reset, `busy` is 0 and `ccd_lines` is all zeros.
- R2: A `start` pulse while idle raises `busy` at the next clock edge. The first pattern word appears on `ccd_lines` one edge later, and each further word follows one clock period after the previous one.
- R3: Within a block, the words are played from the base address upward in strict order, and bit i of each word appears on line i.
- R4: A program word uses bits [9:0] for the base address and bits [19:10] for the length field L. The block then plays L+1 words.
- R5: Bits [27:20] hold the repeat field N. The block is played N+1 times back to back, with no gap between passes.
- R6: Program entries run in order from entry 0. When bit [28] (the final flag) is set, `busy` falls at the same edge that registers that entry's last word.
- R7: While `busy` is 0, `ccd_lines` keeps the last word that was played.
- R8: A `stop` pulse while busy clears `busy` at that edge. No word is played at that edge or after it, so the lines keep the previous word.
- R9: Writes to either memory while `busy` is 1 are ignored.
- R10: A `start` while busy does not restart or disturb the program, and a `stop` while idle has no effect.
- R11: Pattern addresses wrap modulo the pattern memory depth (1024), so a block may cross from the top of the memory back to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock; one pattern word per period |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the program from entry 0 |
| stop | input | 1 | Halt the running program |
| pat_we | input | 1 | Pattern memory write enable |
| pat_waddr | input | 10 | Pattern memory write address |
| pat_wdata | input | 16 | Pattern word to write |
| prg_we | input | 1 | Program memory write enable |
| prg_waddr | input | 6 | Program memory write address |
| prg_wdata | input | 29 | Program entry to write |
| busy | output | 1 | Program running |
| ccd_lines | output | 16 | Registered clock and control lines |

## Verification
Two things can fall in the same cycle: a stop request and the emission of the next word, and a memory write or start request and a running program. The bench raises stop in the cycle just before the sixth word of a long block would be played. It then expects exactly five words, `busy` low, and the fifth word held on the lines. During another run it writes both memories and pulses start. The stream is judged against a model that ignored those writes, and a rerun afterwards shows that the memory contents are unchanged.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Pattern address of word `off` inside a block at `base`; depth is a power of two.
  function automatic logic [31:0] wrap_add(input logic [31:0] base,
                                           input logic [31:0] off,
                                           input logic [31:0] depth);
    return (base + off) & (depth - 32'd1);
  endfunction

endpackage

// File: rtl/ccd_seq_pat_mem.sv
module ccd_seq_pat_mem #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic              wr_ok;

  assign wr_ok = we && !busy;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R9
  pat_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we) |=> (mem[$past(waddr)] == $past(mem[waddr])));

endmodule

// File: rtl/ccd_seq_prg_mem.sv
module ccd_seq_prg_mem #(
  parameter int WORD_W = 29,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic              wr_ok;

  assign wr_ok = we && !busy;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R9
  prg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we) |=> (mem[$past(waddr)] == $past(mem[waddr])));

endmodule

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int PAT_DEPTH = 1024,
  parameter int PRG_DEPTH = 64,
  parameter int REP_W     = 8,
  localparam int PAT_AW   = $clog2(PAT_DEPTH),
  localparam int PRG_AW   = $clog2(PRG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [PAT_AW-1:0] e_base,
  input  logic [PAT_AW-1:0] e_len,
  input  logic [REP_W-1:0]  e_rep,
  input  logic              e_last,
  output logic              busy,
  output logic              emit,
  output logic              finish,
  output logic [PRG_AW-1:0] prg_addr,
  output logic [PAT_AW-1:0] pat_addr
);

  seq_state_e        state_q;
  logic [PRG_AW-1:0] pc_q;
  logic [PAT_AW-1:0] idx_q;
  logic [REP_W-1:0]  rep_q;
  logic              blk_end;
  logic              rep_end;
  logic [31:0]       addr_sum;

  assign busy     = (state_q == SEQ_RUN);
  assign emit     = busy && !stop;
  assign blk_end  = (idx_q == e_len);
  assign rep_end  = (rep_q == e_rep);
  assign finish   = emit && blk_end && rep_end && e_last;
  assign prg_addr = pc_q;
  assign addr_sum = wrap_add(32'(e_base), 32'(idx_q), 32'(PAT_DEPTH));
  assign pat_addr = addr_sum[PAT_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pc_q    <= '0;
      idx_q   <= '0;
      rep_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_RUN;
            pc_q    <= '0;
            idx_q   <= '0;
            rep_q   <= '0;
          end
        end
        SEQ_RUN: begin
          if (stop) begin
            state_q <= SEQ_IDLE;
          end else if (!blk_end) begin
            idx_q <= idx_q + 1'b1;
          end else begin
            idx_q <= '0;
            if (!rep_end) begin
              rep_q <= rep_q + 1'b1;
            end else begin
              rep_q <= '0;
              if (e_last) state_q <= SEQ_IDLE;
              else        pc_q    <= pc_q + 1'b1;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R6
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stop && !finish) |=> busy);

  // R8
  stop_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop) |=> !busy);

  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q <= e_len));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !stop && !blk_end) |=> (idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/ccd_seq_top.sv
module ccd_seq_top #(
  parameter int LINES     = 16,
  parameter int PAT_DEPTH = 1024,
  parameter int PRG_DEPTH = 64,
  parameter int REP_W     = 8,
  localparam int PAT_AW   = $clog2(PAT_DEPTH),
  localparam int PRG_AW   = $clog2(PRG_DEPTH),
  localparam int PRG_W    = 2 * PAT_AW + REP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              pat_we,
  input  logic [PAT_AW-1:0] pat_waddr,
  input  logic [LINES-1:0]  pat_wdata,
  input  logic              prg_we,
  input  logic [PRG_AW-1:0] prg_waddr,
  input  logic [PRG_W-1:0]  prg_wdata,
  output logic              busy,
  output logic [LINES-1:0]  ccd_lines
);

  logic              emit;
  logic              finish;
  logic [PRG_AW-1:0] prg_addr;
  logic [PAT_AW-1:0] pat_addr;
  logic [PRG_W-1:0]  entry;
  logic [LINES-1:0]  pat_word;

  ccd_seq_prg_mem #(.WORD_W(PRG_W), .DEPTH(PRG_DEPTH)) u_prg (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .we(prg_we), .waddr(prg_waddr), .wdata(prg_wdata),
    .raddr(prg_addr), .rdata(entry)
  );

  ccd_seq_pat_mem #(.WORD_W(LINES), .DEPTH(PAT_DEPTH)) u_pat (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .we(pat_we), .waddr(pat_waddr), .wdata(pat_wdata),
    .raddr(pat_addr), .rdata(pat_word)
  );

  ccd_seq_ctrl #(.PAT_DEPTH(PAT_DEPTH), .PRG_DEPTH(PRG_DEPTH), .REP_W(REP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .e_base(entry[PAT_AW-1:0]),
    .e_len(entry[2*PAT_AW-1:PAT_AW]),
    .e_rep(entry[2*PAT_AW+REP_W-1:2*PAT_AW]),
    .e_last(entry[PRG_W-1]),
    .busy(busy), .emit(emit), .finish(finish),
    .prg_addr(prg_addr), .pat_addr(pat_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    ccd_lines <= '0;
    else if (emit) ccd_lines <= pat_word;
  end

  // R7
  lines_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !emit |=> $stable(ccd_lines));

  // R6
  finish_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy);

endmodule

// File: tb/test_ccd_seq_top.sv
module test_ccd_seq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0;
  logic        pat_we = 1'b0, prg_we = 1'b0;
  logic [9:0]  pat_waddr = '0;
  logic [15:0] pat_wdata = '0;
  logic [5:0]  prg_waddr = '0;
  logic [28:0] prg_wdata = '0;
  logic        busy;
  logic [15:0] ccd_lines;

  ccd_seq_top i_ccd_seq_top (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .pat_we(pat_we), .pat_waddr(pat_waddr), .pat_wdata(pat_wdata),
    .prg_we(prg_we), .prg_waddr(prg_waddr), .prg_wdata(prg_wdata),
    .busy(busy), .ccd_lines(ccd_lines)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] pat_m [1024];
  logic [28:0] prg_m [64];
  logic [15:0] exp_q [$];
  logic [15:0] last_word = '0;
  bit stop_mode = 0;
  bit p_busy = 0, p_stop = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [28:0] enc(input int base, input int len, input int rep, input bit last);
    return {last, 8'(rep), 10'(len), 10'(base)};
  endfunction

  // Monitor: a word is due whenever busy was high and stop low before the edge.
  always @(negedge clk) begin
    if (rst_n && p_busy && !p_stop) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected word", ccd_lines, 32'hDEAD);
      end else begin
        logic [15:0] w;
        w = exp_q.pop_front();
        last_word = w;
        check("R3 word stream", ccd_lines, w);
        if (exp_q.size() == 0 && !stop_mode) check("R6 busy at final word", busy, 0);
      end
    end
    p_busy = busy;
    p_stop = stop;
  end

  task automatic wr_pat(input int a, input logic [15:0] d, input bit upd);
    @(posedge clk); #1;
    pat_we = 1; pat_waddr = 10'(a); pat_wdata = d;
    @(posedge clk); #1;
    pat_we = 0;
    if (upd) pat_m[a] = d;
  endtask

  task automatic wr_prg(input int a, input logic [28:0] d, input bit upd);
    @(posedge clk); #1;
    prg_we = 1; prg_waddr = 6'(a); prg_wdata = d;
    @(posedge clk); #1;
    prg_we = 0;
    if (upd) prg_m[a] = d;
  endtask

  // Reference: expand the program from the requirement's field layout.
  task automatic expect_prog(input int limit);
    int pc = 0;
    int cnt = 0;
    for (int e = 0; e < 64; e++) begin
      logic [28:0] p;
      p = prg_m[pc];
      for (int r = 0; r <= int'(p[27:20]); r++)
        for (int i = 0; i <= int'(p[19:10]); i++)
          if (cnt < limit) begin
            exp_q.push_back(pat_m[(int'(p[9:0]) + i) % 1024]);
            cnt++;
          end
      if (p[28]) break;
      pc = (pc + 1) % 64;
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1; start = 1;
    @(posedge clk); #1; start = 0;
  endtask

  task automatic wait_done(input string req);
    for (int k = 0; k < 5000 && (exp_q.size() != 0 || busy); k++) @(negedge clk);
    check(req, exp_q.size(), 0);
    check(req, busy, 0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 lines after reset", ccd_lines, 0);

    for (int a = 0; a < 1024; a += 1)
      if (a < 16 || (a >= 300 && a < 316) || (a >= 1020) || (a >= 96 && a < 104) || (a >= 196 && a < 206))
        wr_pat(a, 16'(a * 16'h9E37 ^ 16'h5A3C), 1);

    // R3 R4 R5 R6: three entries, the first repeated
    wr_prg(0, enc(10, 2, 1, 0), 1);
    wr_prg(1, enc(100, 0, 0, 0), 1);
    wr_prg(2, enc(200, 4, 0, 1), 1);
    expect_prog(100000);
    check("R4 R5 expected count", exp_q.size(), 12);
    pulse_start();
    @(negedge clk);
    check("R2 busy after start", busy, 1);
    wait_done("R6 program end");
    repeat (4) @(negedge clk);
    check("R7 lines hold", ccd_lines, last_word);

    // R10: stop while idle has no effect
    @(posedge clk); #1 stop = 1;
    @(posedge clk); #1 stop = 0;
    @(negedge clk);
    check("R10 stop idle busy", busy, 0);
    check("R10 stop idle lines", ccd_lines, last_word);

    // R11: block crossing the top of the pattern memory
    wr_prg(0, enc(1022, 3, 0, 1), 1);
    expect_prog(100000);
    pulse_start();
    wait_done("R11 wrap");

    // R9 R10: writes and start while running
    wr_prg(0, enc(300, 7, 3, 1), 1);
    expect_prog(100000);
    pulse_start();
    wr_pat(301, 16'hFFFF, 0);
    wr_prg(0, enc(0, 0, 0, 1), 0);
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    wait_done("R10 start while busy");
    expect_prog(100000);
    pulse_start();
    wait_done("R9 memories unchanged");

    // R8: stop lands on the cycle of the sixth word
    stop_mode = 1;
    expect_prog(5);
    pulse_start();
    repeat (5) @(posedge clk);
    #1 stop = 1;
    @(posedge clk); #1 stop = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 busy after stop", busy, 0);
      check("R8 lines after stop", ccd_lines, pat_m[304]);
    end
    check("R8 words before stop", exp_q.size(), 0);
    stop_mode = 0;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule